// File: doc/BRIEF.md
# Converter Result Parallel Read Port

This block sits between a conversion sequencer and a host data bus. When the sequencer's busy flag falls at the end of a conversion, the block captures the finished result word. It then drives that word onto a parallel bus whenever the host asserts both chip-select and read-enable, which are active low. The bus can be configured as a full-width bus, as a 16-bit bus, or as a byte-wide bus. In the narrow configurations the host picks each part of the result with address lines.

The host may read after a conversion ends, during the acquisition phase that follows. It may instead read while the next conversion runs. In that case the bus carries the previous result until busy falls. A monitor raises a status flag when a read falls in the second half of a conversion, which is the part of a conversion where reading is discouraged. High impedance is modelled as a low output enable with the data forced to zero.

Top module: `conv_rdport`

## Requirements
- R1: While reset (`rst`, active high) is asserted, `oe_o` and `late_o` are 0. After reset the captured result is zero, so every read returns 0 until a conversion completes.
- R2: `oe_o` is 1 exactly when `cs_n_i` and `rd_n_i` are both 0 and reset is low. Whenever `oe_o` is 0, `data_o` is all zeros.
- R3: The captured result changes only at a rising clock edge where `busy_i` is sampled 0 after being sampled 1 at the previous edge. At that edge it loads `conv_data_i`. While busy is high, changes on `conv_data_i` do not reach the bus.
- R4: With `width_i` = 0 (full width), `data_o` carries all 18 result bits.
- R5: With `width_i` = 1 (16-bit), only `addr_i[0]` is used. When it is 0, `data_o[15:0]` carries result bits 17..2. When it is 1, `data_o[15:0]` carries result bits 1..0 in bits 1..0, padded with zeros. `data_o[17:16]` is 0.
- R6: With `width_i` = 2 (byte), `data_o[7:0]` carries a byte chosen by `addr_i`. Address 0 gives result bits 17..10 and address 1 gives bits 9..2. Address 2 or 3 gives bits 1..0, padded with zeros. The upper bus bits are 0. Reads may go high, low, then high again.
- R7: `width_i` = 3 behaves exactly like full width.
- R8: With chip-select and read-enable held low across the end of a conversion, the bus shows the previous result until the busy-falling edge. From that edge on it shows the new result.
- R9: `late_o` is 1 exactly when a read is active, `busy_i` is 1, and at least CONV_CYCLES/2 rising edges of the current conversion have already seen busy high. With the defaults this threshold is 4.
- R10: The conversion-phase count restarts with every conversion, so an early read in a later conversion is not flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| busy_i | input | 1 | Conversion in progress flag from the sequencer |
| conv_data_i | input | 18 | Result word offered by the sequencer |
| cs_n_i | input | 1 | Chip-select, active low |
| rd_n_i | input | 1 | Read-enable, active low |
| width_i | input | 2 | Bus width: 0 full, 1 16-bit, 2 byte, 3 full |
| addr_i | input | 2 | Part select for the narrow widths |
| data_o | output | 18 | Bus data (zero when not enabled) |
| oe_o | output | 1 | Bus drive enable (0 means high impedance) |
| late_o | output | 1 | Read active in the second half of a conversion |

## Verification
The bench changes `conv_data_i` in the middle of a conversion. A capture that loaded on a level rather than on the busy fall would let this garbage onto the bus. It holds a continuous read across the busy fall and samples on both sides of that edge. A one-cycle-early or one-cycle-late capture would then show the wrong word. It probes the late-read flag one edge below and at the half-way threshold, and again after a new conversion starts. An off-by-one comparison, or a counter that is never cleared, would either flag the early read or miss the late one. The narrow modes are checked at every address, including the padded tail lanes and the unused address bit in 16-bit mode, where a wrong slice offset or a missing zero-fill shows at once.

// File: rtl/conv_rdport_pkg.sv
package conv_rdport_pkg;
   typedef enum logic [1:0] {
      BW_FULL = 2'd0,
      BW_WORD = 2'd1,
      BW_BYTE = 2'd2,
      BW_ALT  = 2'd3
   } bus_width_e;
endpackage

// File: rtl/conv_rdport_capture.sv
module conv_rdport_capture #(
   parameter int RES_W = 18
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             busy_i,
   input  logic [RES_W-1:0] conv_data_i,
   output logic [RES_W-1:0] result_o
);
   logic busy_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         busy_q   <= 1'b0;
         result_o <= '0;
      end else begin
         busy_q <= busy_i;
         if (busy_q && !busy_i)
            result_o <= conv_data_i;
      end
   end
endmodule

// File: rtl/conv_rdport_slicer.sv
// Cuts a result word into MSB-first lanes; the tail lane is right-aligned
// and zero padded. The lane picked by the address clamps to the last one.
module conv_rdport_slicer #(
   parameter int RES_W  = 18,
   parameter int LANE_W = 8,
   parameter int NLANES = (RES_W + LANE_W - 1) / LANE_W,
   parameter int SEL_W  = (NLANES > 1) ? $clog2(NLANES) : 1
) (
   input  logic [RES_W-1:0]  result_i,
   input  logic [SEL_W-1:0]  sel_i,
   output logic [LANE_W-1:0] lane_o
);
   logic [NLANES-1:0][LANE_W-1:0] lanes;
   logic [SEL_W-1:0]              idx;

   for (genvar i = 0; i < NLANES; i++) begin : g_lane
      localparam int TOP = RES_W - 1 - i * LANE_W;
      localparam int BOT = (TOP - LANE_W + 1 < 0) ? 0 : TOP - LANE_W + 1;
      localparam int W   = TOP - BOT + 1;
      if (W == LANE_W) begin : g_full
         assign lanes[i] = result_i[TOP:BOT];
      end else begin : g_tail
         assign lanes[i] = {{(LANE_W - W){1'b0}}, result_i[TOP:BOT]};
      end
   end

   if ((2 ** SEL_W) > NLANES) begin : g_clamp
      always_comb begin
         idx = sel_i;
         if (int'(sel_i) >= NLANES)
            idx = SEL_W'(NLANES - 1);
      end
   end else begin : g_noclamp
      assign idx = sel_i;
   end

   assign lane_o = lanes[idx];
endmodule

// File: rtl/conv_rdport_window.sv
module conv_rdport_window #(
   parameter int CONV_CYCLES = 8
) (
   input  logic clk,
   input  logic rst,
   input  logic busy_i,
   input  logic read_i,
   output logic late_o
);
   localparam int CNT_W = $clog2(CONV_CYCLES + 1);
   localparam int HALF  = CONV_CYCLES / 2;

   logic [CNT_W-1:0] phase_q;

   always_ff @(posedge clk) begin
      if (rst || !busy_i)
         phase_q <= '0;
      else if (int'(phase_q) < CONV_CYCLES)
         phase_q <= phase_q + 1'b1;
   end

   assign late_o = !rst && busy_i && read_i && (int'(phase_q) >= HALF);
endmodule

// File: rtl/conv_rdport.sv
module conv_rdport #(
   parameter int RES_W       = 18,
   parameter int WORD_W      = 16,
   parameter int BYTE_W      = 8,
   parameter int ADDR_W      = 2,
   parameter int CONV_CYCLES = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              busy_i,
   input  logic [RES_W-1:0]  conv_data_i,
   input  logic              cs_n_i,
   input  logic              rd_n_i,
   input  logic [1:0]        width_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic [RES_W-1:0]  data_o,
   output logic              oe_o,
   output logic              late_o
);
   import conv_rdport_pkg::*;

   localparam int NWORDS = (RES_W + WORD_W - 1) / WORD_W;
   localparam int NBYTES = (RES_W + BYTE_W - 1) / BYTE_W;
   localparam int WSEL_W = (NWORDS > 1) ? $clog2(NWORDS) : 1;
   localparam int BSEL_W = (NBYTES > 1) ? $clog2(NBYTES) : 1;

   if (!(RES_W > WORD_W && WORD_W > BYTE_W && BYTE_W > 0)) begin : g_bad_width
      $error("conv_rdport: need RES_W > WORD_W > BYTE_W > 0");
   end
   if (ADDR_W < BSEL_W || ADDR_W < WSEL_W) begin : g_bad_addr
      $error("conv_rdport: ADDR_W too narrow for the lane count");
   end
   if (CONV_CYCLES < 2) begin : g_bad_conv
      $error("conv_rdport: CONV_CYCLES must be at least 2");
   end

   logic [RES_W-1:0]  result;
   logic [WORD_W-1:0] word_lane;
   logic [BYTE_W-1:0] byte_lane;
   logic [RES_W-1:0]  bus_val;
   logic              read_act;

   conv_rdport_capture #(.RES_W(RES_W)) u_cap (
      .clk         (clk),
      .rst         (rst),
      .busy_i      (busy_i),
      .conv_data_i (conv_data_i),
      .result_o    (result)
   );

   conv_rdport_slicer #(.RES_W(RES_W), .LANE_W(WORD_W)) u_word (
      .result_i (result),
      .sel_i    (addr_i[WSEL_W-1:0]),
      .lane_o   (word_lane)
   );

   conv_rdport_slicer #(.RES_W(RES_W), .LANE_W(BYTE_W)) u_byte (
      .result_i (result),
      .sel_i    (addr_i[BSEL_W-1:0]),
      .lane_o   (byte_lane)
   );

   always_comb begin
      case (bus_width_e'(width_i))
         BW_WORD: bus_val = RES_W'(word_lane);
         BW_BYTE: bus_val = RES_W'(byte_lane);
         default: bus_val = result;
      endcase
   end

   assign read_act = !cs_n_i && !rd_n_i;
   assign oe_o     = read_act && !rst;
   assign data_o   = oe_o ? bus_val : '0;

   conv_rdport_window #(.CONV_CYCLES(CONV_CYCLES)) u_win (
      .clk    (clk),
      .rst    (rst),
      .busy_i (busy_i),
      .read_i (read_act),
      .late_o (late_o)
   );
endmodule

// File: rtl/conv_rdport_chk.sv
module conv_rdport_chk #(
   parameter int RES_W  = 18,
   parameter int WORD_W = 16,
   parameter int BYTE_W = 8,
   parameter int ADDR_W = 2
) (
   input logic              clk,
   input logic              rst,
   input logic              busy_i,
   input logic              cs_n_i,
   input logic              rd_n_i,
   input logic [1:0]        width_i,
   input logic [ADDR_W-1:0] addr_i,
   input logic [RES_W-1:0]  data_o,
   input logic              oe_o,
   input logic              late_o
);
   assert_reset_clear_R1: assert property (@(posedge clk)
      rst |-> (!oe_o && !late_o));

   assert_reset_result_R1: assert property (@(posedge clk)
      rst |=> (data_o == '0));

   assert_hiz_R2: assert property (@(posedge clk) disable iff (rst)
      (cs_n_i || rd_n_i) |-> (!oe_o && data_o == '0));

   assert_hold_busy_R3: assert property (@(posedge clk) disable iff (rst)
      ($past(busy_i) && $stable(cs_n_i) && $stable(rd_n_i) &&
       $stable(width_i) && $stable(addr_i)) |-> $stable(data_o));

   assert_word_upper_zero_R5: assert property (@(posedge clk) disable iff (rst)
      (width_i == 2'd1) |-> (data_o[RES_W-1:WORD_W] == '0));

   assert_byte_upper_zero_R6: assert property (@(posedge clk) disable iff (rst)
      (width_i == 2'd2) |-> (data_o[RES_W-1:BYTE_W] == '0));

   assert_late_needs_read_R9: assert property (@(posedge clk) disable iff (rst)
      late_o |-> (busy_i && !cs_n_i && !rd_n_i));
endmodule

bind conv_rdport conv_rdport_chk #(
   .RES_W(RES_W), .WORD_W(WORD_W), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W)
) u_chk (
   .clk     (clk),
   .rst     (rst),
   .busy_i  (busy_i),
   .cs_n_i  (cs_n_i),
   .rd_n_i  (rd_n_i),
   .width_i (width_i),
   .addr_i  (addr_i),
   .data_o  (data_o),
   .oe_o    (oe_o),
   .late_o  (late_o)
);

// File: tb/conv_rdport_tb_top.sv
module conv_rdport_tb_top;
   localparam int CLK_P = 10;
   localparam int NVEC  = 15;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        busy_i = 1'b0;
   logic [17:0] conv_data_i = '0;
   logic        cs_n_i = 1'b1;
   logic        rd_n_i = 1'b1;
   logic [1:0]  width_i = 2'd0;
   logic [1:0]  addr_i = 2'd0;
   logic [17:0] data_o;
   logic        oe_o;
   logic        late_o;

   int  n_chk  = 0;
   int  n_fail = 0;
   bit  done   = 1'b0;

   // {result[17:0], width[1:0], addr[1:0], expected bus[17:0]}
   localparam logic [39:0] VEC [NVEC] = '{
      {18'h2A5C3, 2'd0, 2'd0, 18'h2A5C3},
      {18'h2A5C3, 2'd1, 2'd0, 18'h0A970},
      {18'h2A5C3, 2'd1, 2'd1, 18'h00003},
      {18'h2A5C3, 2'd2, 2'd0, 18'h000A9},
      {18'h2A5C3, 2'd2, 2'd1, 18'h00070},
      {18'h2A5C3, 2'd2, 2'd2, 18'h00003},
      {18'h2A5C3, 2'd2, 2'd3, 18'h00003},
      {18'h2A5C3, 2'd3, 2'd0, 18'h2A5C3},
      {18'h10F0E, 2'd0, 2'd0, 18'h10F0E},
      {18'h10F0E, 2'd1, 2'd2, 18'h043C3},
      {18'h10F0E, 2'd1, 2'd3, 18'h00002},
      {18'h10F0E, 2'd2, 2'd0, 18'h00043},
      {18'h10F0E, 2'd2, 2'd1, 18'h000C3},
      {18'h10F0E, 2'd2, 2'd0, 18'h00043},
      {18'h10F0E, 2'd2, 2'd2, 18'h00002}
   };

   conv_rdport dut_i (
      .clk(clk), .rst(rst), .busy_i(busy_i), .conv_data_i(conv_data_i),
      .cs_n_i(cs_n_i), .rd_n_i(rd_n_i), .width_i(width_i), .addr_i(addr_i),
      .data_o(data_o), .oe_o(oe_o), .late_o(late_o)
   );

   always #(CLK_P / 2) clk = ~clk;

   task automatic check(input string req, input logic [17:0] act, input logic [17:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic convert(input logic [17:0] res);
      @(negedge clk);
      busy_i = 1'b1;
      conv_data_i = ~res;
      repeat (3) @(posedge clk);
      @(negedge clk);
      conv_data_i = res;
      busy_i = 1'b0;
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [17:0] loaded;
      string tag;
      // R1: reset state, even with a read requested
      repeat (3) @(posedge clk);
      @(negedge clk);
      cs_n_i = 1'b0; rd_n_i = 1'b0;
      #1;
      check("R1 oe in reset", 18'(oe_o), 18'd0);
      check("R1 late in reset", 18'(late_o), 18'd0);
      check("R1 data in reset", data_o, 18'd0);
      rst = 1'b0;
      @(negedge clk);
      #1;
      check("R1 result zero after reset", data_o, 18'd0);
      check("R2 oe during read", 18'(oe_o), 18'd1);
      cs_n_i = 1'b1; rd_n_i = 1'b1;

      // vector table: R4..R7
      loaded = '0;
      for (int i = 0; i < NVEC; i++) begin
         if (VEC[i][39:22] != loaded) begin
            convert(VEC[i][39:22]);
            loaded = VEC[i][39:22];
         end
         @(negedge clk);
         width_i = VEC[i][21:20];
         addr_i  = VEC[i][19:18];
         cs_n_i  = 1'b0; rd_n_i = 1'b0;
         #1;
         case (VEC[i][21:20])
            2'd0: tag = "R4 full";
            2'd1: tag = "R5 word";
            2'd2: tag = "R6 byte";
            default: tag = "R7 alt";
         endcase
         check(tag, data_o, VEC[i][17:0]);
         @(negedge clk);
         cs_n_i = 1'b1; rd_n_i = 1'b1;
      end

      // R2: partial strobes keep the bus high impedance
      @(negedge clk);
      width_i = 2'd0; addr_i = 2'd0;
      cs_n_i = 1'b1; rd_n_i = 1'b0;
      #1;
      check("R2 cs high oe", 18'(oe_o), 18'd0);
      check("R2 cs high data", data_o, 18'd0);
      cs_n_i = 1'b0; rd_n_i = 1'b1;
      #1;
      check("R2 rd high oe", 18'(oe_o), 18'd0);
      check("R2 rd high data", data_o, 18'd0);

      // R3/R8/R9: continuous read through a conversion
      @(negedge clk);
      busy_i = 1'b1; conv_data_i = 18'h3FFFF; rd_n_i = 1'b0;
      #1;
      check("R3 previous result while busy", data_o, 18'h10F0E);
      check("R9 no flag at start", 18'(late_o), 18'd0);
      repeat (3) @(posedge clk);
      @(negedge clk);
      conv_data_i = 18'h12345;
      #1;
      check("R9 no flag below half", 18'(late_o), 18'd0);
      check("R3 input change ignored", data_o, 18'h10F0E);
      @(posedge clk);
      @(negedge clk);
      #1;
      check("R9 flag at half", 18'(late_o), 18'd1);
      rd_n_i = 1'b1;
      #1;
      check("R9 no flag without read", 18'(late_o), 18'd0);
      rd_n_i = 1'b0;
      conv_data_i = 18'h2A5C3; busy_i = 1'b0;
      #1;
      check("R8 old data before edge", data_o, 18'h10F0E);
      @(posedge clk);
      @(negedge clk);
      #1;
      check("R8 new data after busy fall", data_o, 18'h2A5C3);
      check("R9 no flag when idle", 18'(late_o), 18'd0);

      // R10: next conversion restarts the phase count
      @(negedge clk);
      busy_i = 1'b1; conv_data_i = 18'h00001;
      repeat (2) @(posedge clk);
      @(negedge clk);
      #1;
      check("R10 early read not flagged", 18'(late_o), 18'd0);
      busy_i = 1'b0;
      @(posedge clk);
      @(negedge clk);
      #1;
      check("R3 new capture", data_o, 18'h00001);

      // R1: reset clears a loaded result
      rst = 1'b1;
      @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      #1;
      check("R1 result cleared by reset", data_o, 18'd0);
      check("R1 oe back after reset", 18'(oe_o), 18'd1);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule